// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Generator

This block produces the single status output of a flash device that tells the host whether the internal write engine is working. It watches the engine's busy flag together with the kind of operation under way, the erase-suspend and program-active flags, a reset/power-down indication and two one-cycle completion strobes, one for program and one for erase.

Out of reset the output works as a plain ready/busy level. A configuration write can instead put it into a pulse mode. In pulse mode the output rests high and gives a fixed-length low pulse when an enabled operation completes. Completions of a type that is not enabled are masked. For example, a background erase can finish without interrupting a host that only wants to hear about programs. Reset or power-down always drives the output high and returns the block to level mode.

Top module: `flash_status_pin`

## Requirements
- R1: While `rstN` is low the pin is high, and after reset the block is in level mode (mode code 2'b00).
- R2: In level mode the pin is low in the same cycle whenever `wsmBusy` is high with `opType` set to erase (2'b01), program (2'b10) or lock configuration (2'b11), unless the R4 exception applies.
- R3: In level mode the pin is high when `wsmBusy` is low, or when `opType` is 2'b00 (no operation).
- R4: In level mode the pin is high while `eraseSuspended` is high and `programActive` is low. It is low if `programActive` is also high while busy.
- R5: `pwrDown` high forces the pin high in the same cycle. At the next edge it returns the mode to level and cancels any pulse. While it is high, configuration writes and completion strobes have no effect.
- R6: A cycle with `cfgWrite` high loads `cfgMode` as the mode at the next edge and cancels any pulse in progress. It takes priority over a completion strobe in the same cycle. Codes: 2'b00 level, 2'b01 pulse on erase completion, 2'b10 pulse on program completion, 2'b11 pulse on either.
- R7: In any pulse mode the pin rests high and ignores the busy, suspend and program-active inputs.
- R8: An enabled completion strobe sampled at an edge drives the pin low for exactly `PULSE_LEN` cycles, starting right after that edge.
- R9: A completion strobe whose type is not enabled in the current mode, or any strobe in level mode, leaves the pin unchanged.
- R10: An enabled strobe that arrives during a pulse restarts the count, so the pin stays low for `PULSE_LEN` cycles after the newest strobe. No second pulse is queued.
- R11: In mode 2'b11 both program and erase completions start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | Reset/power-down indication, forces the pin high |
| cfgWrite | input | 1 | One-cycle configuration write strobe |
| cfgMode | input | 2 | Mode code loaded on `cfgWrite` |
| wsmBusy | input | 1 | Write engine busy |
| opType | input | 2 | Operation under way: 00 none, 01 erase, 10 program, 11 lock |
| eraseSuspended | input | 1 | Erase is suspended |
| programActive | input | 1 | A program operation is active |
| doneProgram | input | 1 | One-cycle program completion strobe |
| doneErase | input | 1 | One-cycle erase completion strobe |
| statusPin | output | 1 | Ready/busy level or completion pulse, active low |

## Verification
In level mode the bench runs each operation type with busy set, then busy with no operation type. This separates the decode of the operation type from the busy flag alone. It then runs suspend with and without an active program, which tells the suspend exception apart from a plain busy.

In each pulse mode the bench sends lone strobes of both types, so a wrong enable mask shows up as a missing or extra pulse. It sends back-to-back strobes partway through a pulse, which separates a restart from a queued or ignored retrigger. It also sends a strobe together with a configuration write, and a strobe during power-down, which exposes the priority order.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL    = 2'b00,
    MODE_ERASE    = 2'b01,
    MODE_PROGRAM  = 2'b10,
    MODE_EITHER   = 2'b11
  } pinMode_t;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_ERASE   = 2'b01,
    OP_PROGRAM = 2'b10,
    OP_LOCK    = 2'b11
  } opKind_t;

  typedef struct packed {
    logic forceHigh;
    logic levelMode;
    logic busyLow;
    logic loadPulse;
    logic clearPulse;
  } ctrlStrobes_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwrDown,
  input  logic         cfgWrite,
  input  logic [1:0]   cfgMode,
  input  logic         wsmBusy,
  input  logic [1:0]   opType,
  input  logic         eraseSuspended,
  input  logic         programActive,
  input  logic         doneProgram,
  input  logic         doneErase,
  output ctrlStrobes_t strobes
);

  pinMode_t   modeQ;
  logic [1:0] modeBits;
  logic       eraseHit;
  logic       programHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeQ <= MODE_LEVEL;
    else if (pwrDown)  modeQ <= MODE_LEVEL;
    else if (cfgWrite) modeQ <= pinMode_t'(cfgMode);
  end

  assign modeBits   = modeQ;
  assign eraseHit   = doneErase   && modeBits[0];
  assign programHit = doneProgram && modeBits[1];

  always_comb begin
    strobes.forceHigh  = pwrDown || !rstN;
    strobes.levelMode  = (modeQ == MODE_LEVEL);
    strobes.busyLow    = wsmBusy && (opKind_t'(opType) != OP_NONE)
                         && !(eraseSuspended && !programActive);
    strobes.clearPulse = pwrDown || cfgWrite;
    strobes.loadPulse  = !pwrDown && !cfgWrite && (eraseHit || programHit);
  end

  // R5: power-down returns the mode to level at the next edge
  assert_pwrdown_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (modeQ == MODE_LEVEL));

  // R6: a configuration write loads the requested mode
  assert_cfg_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !pwrDown) |=> (modeBits == $past(cfgMode)));

endmodule

// File: rtl/flash_status_datapath.sv
module flash_status_datapath
  import flash_status_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         statusPin
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] pulseCnt;
  logic             pulseOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pulseCnt <= '0;
    else if (strobes.clearPulse) pulseCnt <= '0;
    else if (strobes.loadPulse)  pulseCnt <= LOAD_VAL;
    else if (pulseCnt != '0)     pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseOn = (pulseCnt != '0);

  always_comb begin
    if (strobes.forceHigh)      statusPin = 1'b1;
    else if (strobes.levelMode) statusPin = !strobes.busyLow;
    else                        statusPin = !pulseOn;
  end

  // R8: an accepted completion pulls the pin low on the next cycle
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadPulse && !strobes.levelMode) |=> (!statusPin || strobes.forceHigh));

  // R10: a restart reloads the full length
  assert_retrigger_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPulse |=> (pulseCnt == LOAD_VAL));

  // R5: power-down always wins
  assert_force_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceHigh |-> statusPin);

  // R7: pulse mode with no pulse running rests high
  assert_rest_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.levelMode && !pulseOn) |-> statusPin);

endmodule

// File: rtl/flash_status_pin.sv
module flash_status_pin
  import flash_status_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       cfgWrite,
  input  logic [1:0] cfgMode,
  input  logic       wsmBusy,
  input  logic [1:0] opType,
  input  logic       eraseSuspended,
  input  logic       programActive,
  input  logic       doneProgram,
  input  logic       doneErase,
  output logic       statusPin
);

  ctrlStrobes_t strobes;

  flash_status_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .pwrDown        (pwrDown),
    .cfgWrite       (cfgWrite),
    .cfgMode        (cfgMode),
    .wsmBusy        (wsmBusy),
    .opType         (opType),
    .eraseSuspended (eraseSuspended),
    .programActive  (programActive),
    .doneProgram    (doneProgram),
    .doneErase      (doneErase),
    .strobes        (strobes)
  );

  flash_status_datapath #(.PULSE_LEN(PULSE_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .statusPin (statusPin)
  );

endmodule

// File: tb/flash_status_pin_tb.sv
module flash_status_pin_tb;

  localparam int PULSE_LEN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDown = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic       wsmBusy = 1'b0;
  logic [1:0] opType = 2'b00;
  logic       eraseSuspended = 1'b0;
  logic       programActive = 1'b0;
  logic       doneProgram = 1'b0;
  logic       doneErase = 1'b0;
  logic       statusPin;

  int    nCompared = 0;
  int    nFailed = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  int mdlMode = 0;
  int mdlCnt = 0;

  always #4 clk = ~clk;

  flash_status_pin #(.PULSE_LEN(PULSE_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .cfgWrite(cfgWrite),
    .cfgMode(cfgMode), .wsmBusy(wsmBusy), .opType(opType),
    .eraseSuspended(eraseSuspended), .programActive(programActive),
    .doneProgram(doneProgram), .doneErase(doneErase), .statusPin(statusPin)
  );

  // Reference model state, updated on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdlMode = 0;
      mdlCnt = 0;
    end else if (pwrDown) begin
      mdlMode = 0;
      mdlCnt = 0;
    end else if (cfgWrite) begin
      mdlMode = int'(cfgMode);
      mdlCnt = 0;
    end else if ((doneErase && (mdlMode == 1 || mdlMode == 3)) ||
                 (doneProgram && (mdlMode == 2 || mdlMode == 3))) begin
      mdlCnt = PULSE_LEN;
    end else if (mdlCnt > 0) begin
      mdlCnt = mdlCnt - 1;
    end
  end

  function automatic logic expectedPin();
    if (!rstN || pwrDown) return 1'b1;
    if (mdlMode == 0) begin
      if (wsmBusy && opType != 2'b00 && !(eraseSuspended && !programActive))
        return 1'b0;
      return 1'b1;
    end
    return (mdlCnt == 0);
  endfunction

  // Compare every cycle, midway between rising edges
  always @(negedge clk) begin
    if (!finished) begin
      logic exp;
      exp = expectedPin();
      nCompared++;
      if (statusPin !== exp) begin
        nFailed++;
        $display("FAIL %s: cycle %0d statusPin=%b expected=%b", curReq, cycles, statusPin, exp);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cycles++;
    end
  endtask

  task automatic strobe(bit prog, bit ers);
    doneProgram = prog;
    doneErase = ers;
    step(1);
    doneProgram = 1'b0;
    doneErase = 1'b0;
  endtask

  task automatic setMode(logic [1:0] m);
    cfgMode = m;
    cfgWrite = 1'b1;
    step(1);
    cfgWrite = 1'b0;
  endtask

  initial begin
    // R1: pin high during and after reset
    curReq = "R1";
    step(3);
    rstN = 1'b1;
    step(2);

    // R2: busy with each real operation type pulls the pin low
    curReq = "R2";
    wsmBusy = 1'b1;
    for (int t = 1; t < 4; t++) begin
      opType = 2'(t);
      step(2);
    end

    // R3: not busy, or busy with no operation, is ready
    curReq = "R3";
    opType = 2'b00;
    step(2);
    wsmBusy = 1'b0;
    opType = 2'b01;
    step(2);

    // R4: suspend exception and its program-active override
    curReq = "R4";
    wsmBusy = 1'b1;
    eraseSuspended = 1'b1;
    step(2);
    programActive = 1'b1;
    opType = 2'b10;
    step(2);
    programActive = 1'b0;
    eraseSuspended = 1'b0;

    // R9: strobes ignored in level mode
    curReq = "R9";
    wsmBusy = 1'b0;
    strobe(1'b1, 1'b1);
    step(2);

    // R8: program pulse mode, full pulse length
    curReq = "R8";
    setMode(2'b10);
    wsmBusy = 1'b1;
    opType = 2'b01;
    // R7: busy ignored in pulse mode
    curReq = "R7";
    step(3);
    curReq = "R8";
    strobe(1'b1, 1'b0);
    step(PULSE_LEN + 2);

    // R9: erase completion masked in program-only mode
    curReq = "R9";
    strobe(1'b0, 1'b1);
    step(PULSE_LEN + 1);

    // R10: retrigger midway restarts
    curReq = "R10";
    strobe(1'b1, 1'b0);
    step(1);
    strobe(1'b1, 1'b0);
    step(PULSE_LEN + 2);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    step(PULSE_LEN + 1);

    // R9: erase-only mode masks program completion
    curReq = "R9";
    setMode(2'b01);
    strobe(1'b1, 1'b0);
    step(PULSE_LEN);
    curReq = "R8";
    strobe(1'b0, 1'b1);
    step(PULSE_LEN + 1);

    // R11: either mode accepts both
    curReq = "R11";
    setMode(2'b11);
    strobe(1'b0, 1'b1);
    step(PULSE_LEN + 1);
    strobe(1'b1, 1'b0);
    step(PULSE_LEN + 1);

    // R6: config write cancels a pulse and beats a same-cycle strobe
    curReq = "R6";
    strobe(1'b1, 1'b0);
    step(1);
    setMode(2'b11);
    step(2);
    doneErase = 1'b1;
    setMode(2'b10);
    doneErase = 1'b0;
    step(PULSE_LEN);

    // R5: power-down forces high, cancels pulse, returns level mode
    curReq = "R5";
    setMode(2'b11);
    strobe(1'b1, 1'b0);
    pwrDown = 1'b1;
    cfgMode = 2'b10;
    cfgWrite = 1'b1;
    doneErase = 1'b1;
    step(2);
    cfgWrite = 1'b0;
    doneErase = 1'b0;
    pwrDown = 1'b0;
    wsmBusy = 1'b1;
    opType = 2'b11;
    step(3);
    wsmBusy = 1'b0;
    step(2);

    // R1: asynchronous reset mid-pulse
    curReq = "R1";
    setMode(2'b11);
    strobe(1'b0, 1'b1);
    #1 rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    wsmBusy = 1'b1;
    opType = 2'b10;
    step(3);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      nFailed++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

endmodule